// File: doc/BRIEF.md
# Sparse Reconfigurable Tap FIR Filter

This block is the channel filter for a single transmit-to-receive path of a 2×2 channel emulator. Input samples advance through a history line that spans `LEN` sample positions, counting the current one. Only `TAPS` multipliers exist. Each multiplier reads the history position named by its own programmable delay index. It scales that sample by its own programmable coefficient. The products are added at full precision, so the output never rounds or saturates. Four of these filters and two adders make the complete 2×2 core. Truncating the output for a converter is left to logic further down the path.

A host port loads delay indices and coefficients into a shadow profile. A commit strobe copies the whole shadow profile into the active profile in one clock edge. This lets the emulated channel switch at run time without a rebuild. Each result is the sum over all taps of the active coefficient times the input delayed by that tap's index. The result leaves the block a fixed number of cycles after its sample is accepted.

Top module: `stf_sparse_fir`

## Requirements
- R1: Reset state. After reset, `out_valid` is 0 and `out_data` is 0. All active and shadow delays and coefficients are 0, and the history line holds zeros. Until the first commit, every result is 0.
- R2: Result value. For the sample x(i) accepted with `in_valid`, `out_data` equals the sum over taps k of c_k·x(i−d_k). Here c_k and d_k are the active profile. Positions before the first sample since reset read as 0. The sum is a signed value `DATA_W+COEF_W+clog2(TAPS)` bits wide, with no rounding or saturation.
- R3: Timing. `out_valid` is 1 for exactly one cycle per accepted sample, three rising edges after the edge that accepts it (`LATENCY` = 3). It is 0 otherwise. `out_data` holds its value while `out_valid` is 0.
- R4: The history line advances only on cycles where `in_valid` is 1. Idle cycles between samples do not change which samples the taps read.
- R5: A host write (`cfg_we`=1) changes only the shadow profile. `cfg_sel`=0 writes the delay of tap `cfg_addr` from the low bits of `cfg_wdata`. `cfg_sel`=1 writes its coefficient as the signed value of `cfg_wdata`. Results do not change until a commit.
- R6: Commit atomicity. When `cfg_commit` is 1, the active profile takes the shadow profile at that edge. A sample accepted in the same cycle uses the old profile. Samples accepted on later cycles use the new one. No result mixes the two profiles.
- R7: A host write in the same cycle as `cfg_commit` lands in the shadow only. That commit does not include it; the next commit does.
- R8: A delay write whose unsigned value exceeds `LEN`−1 stores `LEN`−1.
- R9: A host write with `cfg_addr` ≥ `TAPS` changes no shadow or active value.
- R10: Delay index 0 selects the sample accepted in the same cycle, and index `LEN`−1 selects the sample `LEN`−1 acceptances earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe; advances the history line |
| in_data | input | DATA_W | Signed input sample |
| cfg_we | input | 1 | Host write strobe to the shadow profile |
| cfg_sel | input | 1 | 0 = delay index, 1 = coefficient |
| cfg_addr | input | clog2(TAPS) | Tap slot being written |
| cfg_wdata | input | COEF_W | Write value: unsigned delay or signed coefficient |
| cfg_commit | input | 1 | Copy shadow profile into active profile |
| out_valid | output | 1 | Result strobe |
| out_data | output | DATA_W+COEF_W+clog2(TAPS) | Signed full-precision result |

## Verification
Two events can fall in the same cycle: a profile commit, and either a sample acceptance or a host write. The bench drives a commit together with `in_valid`, and separately drives a commit together with `cfg_we`. It also scatters all three at random over several thousand cycles. A behavioural model applies each cycle in a fixed order: the sample is evaluated with the old profile, then the shadow is copied, then the write lands in the shadow. The model then compares every output cycle against the design. A result that mixes old and new coefficients, or a commit that takes in a same-cycle write, shows up as a data mismatch on the affected sample.

// File: rtl/stf_pkg.sv
package stf_pkg;

  localparam int unsigned STF_DATA_W = 14;
  localparam int unsigned STF_COEF_W = 16;
  localparam int unsigned STF_LEN    = 64;
  localparam int unsigned STF_TAPS   = 9;

  // Pipeline depth: operand capture, product, summation.
  localparam int unsigned STF_LATENCY = 3;

  typedef enum logic {
    CFG_DELAY = 1'b0,
    CFG_COEF  = 1'b1
  } cfg_tgt_e;

endpackage

// File: rtl/stf_delay_line.sv
module stf_delay_line #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned LEN    = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic [DATA_W-1:0]            din,
  output logic [LEN-1:0][DATA_W-1:0]   win
);

  logic [LEN-2:0][DATA_W-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) begin
      hist_d[0] = din;
      for (int k = 1; k < LEN - 1; k++) begin
        hist_d[k] = hist_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  // Position 0 is the sample presented this cycle.
  assign win = {hist_q, din};

endmodule

// File: rtl/stf_tap_bank.sv
module stf_tap_bank
  import stf_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned LEN    = 64,
  parameter int unsigned TAPS   = 9,
  localparam int unsigned DLY_W = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int unsigned AW    = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic                           cfg_sel,
  input  logic [AW-1:0]                  cfg_addr,
  input  logic [COEF_W-1:0]              cfg_wdata,
  input  logic                           cfg_commit,
  output logic [TAPS-1:0][DLY_W-1:0]     act_dly,
  output logic [TAPS-1:0][COEF_W-1:0]    act_coef,
  output logic [TAPS-1:0][DLY_W-1:0]     shd_dly,
  output logic [TAPS-1:0][COEF_W-1:0]    shd_coef
);

  localparam logic [COEF_W-1:0] MAX_DLY = COEF_W'(LEN - 1);

  logic [TAPS-1:0][DLY_W-1:0]  shd_dly_q,  shd_dly_d;
  logic [TAPS-1:0][COEF_W-1:0] shd_coef_q, shd_coef_d;
  logic [TAPS-1:0][DLY_W-1:0]  act_dly_q,  act_dly_d;
  logic [TAPS-1:0][COEF_W-1:0] act_coef_q, act_coef_d;

  logic             addr_ok;
  logic [DLY_W-1:0] dly_wval;
  cfg_tgt_e         tgt;

  assign tgt      = cfg_tgt_e'(cfg_sel);
  assign addr_ok  = ({1'b0, cfg_addr} < (AW + 1)'(TAPS));
  assign dly_wval = (cfg_wdata > MAX_DLY) ? DLY_W'(MAX_DLY) : DLY_W'(cfg_wdata);

  // Shadow profile next state.
  always_comb begin
    shd_dly_d  = shd_dly_q;
    shd_coef_d = shd_coef_q;
    if (cfg_we && addr_ok) begin
      for (int t = 0; t < TAPS; t++) begin
        if (cfg_addr == AW'(t)) begin
          if (tgt == CFG_COEF) begin
            shd_coef_d[t] = cfg_wdata;
          end else begin
            shd_dly_d[t] = dly_wval;
          end
        end
      end
    end
  end

  // Active profile next state: whole-profile copy of the pre-edge shadow.
  always_comb begin
    act_dly_d  = act_dly_q;
    act_coef_d = act_coef_q;
    if (cfg_commit) begin
      act_dly_d  = shd_dly_q;
      act_coef_d = shd_coef_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_dly_q  <= '0;
      shd_coef_q <= '0;
      act_dly_q  <= '0;
      act_coef_q <= '0;
    end else begin
      shd_dly_q  <= shd_dly_d;
      shd_coef_q <= shd_coef_d;
      act_dly_q  <= act_dly_d;
      act_coef_q <= act_coef_d;
    end
  end

  assign act_dly  = act_dly_q;
  assign act_coef = act_coef_q;
  assign shd_dly  = shd_dly_q;
  assign shd_coef = shd_coef_q;

endmodule

// File: rtl/stf_tap_lane.sv
module stf_tap_lane #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned LEN    = 64,
  localparam int unsigned DLY_W  = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel_en,
  input  logic                        prod_en,
  input  logic [LEN-1:0][DATA_W-1:0]  win,
  input  logic [DLY_W-1:0]            dly,
  input  logic [COEF_W-1:0]           coef,
  output logic [PROD_W-1:0]           prod
);

  logic [DATA_W-1:0]        opnd_q, opnd_d;
  logic [COEF_W-1:0]        coef_q, coef_d;
  logic [PROD_W-1:0]        prod_q, prod_d;
  logic signed [PROD_W-1:0] opnd_ext, coef_ext;

  assign opnd_ext = PROD_W'($signed(opnd_q));
  assign coef_ext = PROD_W'($signed(coef_q));

  always_comb begin
    opnd_d = opnd_q;
    coef_d = coef_q;
    if (sel_en) begin
      opnd_d = win[dly];
      coef_d = coef;
    end
  end

  always_comb begin
    prod_d = prod_q;
    if (prod_en) begin
      prod_d = opnd_ext * coef_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      coef_q <= '0;
      prod_q <= '0;
    end else begin
      opnd_q <= opnd_d;
      coef_q <= coef_d;
      prod_q <= prod_d;
    end
  end

  assign prod = prod_q;

endmodule

// File: rtl/stf_adder_tree.sv
module stf_adder_tree #(
  parameter int unsigned IN_W  = 30,
  parameter int unsigned CNT   = 9,
  localparam int unsigned LVLS  = (CNT > 1) ? $clog2(CNT) : 0,
  localparam int unsigned SLOTS = 1 << LVLS,
  localparam int unsigned OUT_W = IN_W + LVLS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [CNT-1:0][IN_W-1:0]   terms,
  output logic [OUT_W-1:0]           sum
);

  logic [OUT_W-1:0] sum_q, sum_d, tree_out;

  always_comb begin
    logic signed [OUT_W-1:0] node [SLOTS];
    for (int i = 0; i < SLOTS; i++) begin
      if (i < CNT) begin
        node[i] = OUT_W'($signed(terms[i]));
      end else begin
        node[i] = '0;
      end
    end
    for (int w = SLOTS / 2; w > 0; w = w / 2) begin
      for (int i = 0; i < w; i++) begin
        node[i] = node[2*i] + node[2*i+1];
      end
    end
    tree_out = node[0];
  end

  always_comb begin
    sum_d = sum_q;
    if (en) begin
      sum_d = tree_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;

endmodule

// File: rtl/stf_sparse_fir.sv
module stf_sparse_fir
  import stf_pkg::*;
#(
  parameter int unsigned DATA_W = STF_DATA_W,
  parameter int unsigned COEF_W = STF_COEF_W,
  parameter int unsigned LEN    = STF_LEN,
  parameter int unsigned TAPS   = STF_TAPS,
  localparam int unsigned DLY_W   = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int unsigned AW      = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int unsigned PROD_W  = DATA_W + COEF_W,
  localparam int unsigned SUM_W   = PROD_W + ((TAPS > 1) ? $clog2(TAPS) : 0),
  localparam int unsigned LATENCY = STF_LATENCY
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [COEF_W-1:0]  cfg_wdata,
  input  logic               cfg_commit,
  output logic               out_valid,
  output logic [SUM_W-1:0]   out_data
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [LEN-1:0][DATA_W-1:0]  win;
  logic [TAPS-1:0][DLY_W-1:0]  act_dly,  shd_dly;
  logic [TAPS-1:0][COEF_W-1:0] act_coef, shd_coef;
  logic [TAPS-1:0][PROD_W-1:0] prods;
  logic [LATENCY-1:0]          vld_q, vld_d;

  stf_delay_line #(
    .DATA_W (DATA_W),
    .LEN    (LEN)
  ) u_line (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (in_valid),
    .din      (in_data),
    .win      (win)
  );

  stf_tap_bank #(
    .COEF_W (COEF_W),
    .LEN    (LEN),
    .TAPS   (TAPS)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_commit (cfg_commit),
    .act_dly    (act_dly),
    .act_coef   (act_coef),
    .shd_dly    (shd_dly),
    .shd_coef   (shd_coef)
  );

  for (genvar t = 0; t < TAPS; t++) begin : g_lane
    stf_tap_lane #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .LEN    (LEN)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .sel_en  (in_valid),
      .prod_en (vld_q[0]),
      .win     (win),
      .dly     (act_dly[t]),
      .coef    (act_coef[t]),
      .prod    (prods[t])
    );
  end

  stf_adder_tree #(
    .IN_W (PROD_W),
    .CNT  (TAPS)
  ) u_tree (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (vld_q[1]),
    .terms (prods),
    .sum   (out_data)
  );

  // Valid pipeline alongside the datapath.
  always_comb begin
    vld_d = {vld_q[LATENCY-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign out_valid = vld_q[LATENCY-1];

endmodule

// File: rtl/stf_sparse_fir_chk.sv
module stf_sparse_fir_chk #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned LEN    = 64,
  parameter int unsigned TAPS   = 9,
  localparam int unsigned DLY_W = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int unsigned AW    = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int unsigned SUM_W = DATA_W + COEF_W + ((TAPS > 1) ? $clog2(TAPS) : 0)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rst_sync_n,
  input logic                        in_valid,
  input logic                        cfg_we,
  input logic                        cfg_sel,
  input logic [AW-1:0]               cfg_addr,
  input logic [COEF_W-1:0]           cfg_wdata,
  input logic                        cfg_commit,
  input logic                        out_valid,
  input logic [SUM_W-1:0]            out_data,
  input logic [TAPS-1:0][DLY_W-1:0]  act_dly,
  input logic [TAPS-1:0][COEF_W-1:0] act_coef,
  input logic [TAPS-1:0][DLY_W-1:0]  shd_dly,
  input logic [TAPS-1:0][COEF_W-1:0] shd_coef
);

  // Edges since internal reset release, saturating.
  logic [1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_cnt <= '0;
    end else if (run_cnt != 2'd3) begin
      run_cnt <= run_cnt + 2'd1;
    end
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (run_cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !out_valid |-> $stable(out_data));

  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !cfg_commit |=> ($stable(act_dly) && $stable(act_coef)));

  p_commit_copy_r6: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    cfg_commit |=> ((act_dly == $past(shd_dly)) && (act_coef == $past(shd_coef))));

  p_addr_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (cfg_we && (int'(cfg_addr) >= TAPS)) |=> ($stable(shd_dly) && $stable(shd_coef)));

  for (genvar t = 0; t < TAPS; t++) begin : g_clamp
    p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
      (cfg_we && !cfg_sel && (int'(cfg_addr) == t) && (int'(cfg_wdata) > LEN - 1))
      |=> (int'(shd_dly[t]) == LEN - 1));
  end

endmodule

bind stf_sparse_fir stf_sparse_fir_chk #(
  .DATA_W (DATA_W),
  .COEF_W (COEF_W),
  .LEN    (LEN),
  .TAPS   (TAPS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .cfg_commit (cfg_commit),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .act_dly    (act_dly),
  .act_coef   (act_coef),
  .shd_dly    (shd_dly),
  .shd_coef   (shd_coef)
);

// File: tb/stf_sparse_fir_test.sv
module stf_sparse_fir_test;

  localparam int DW = 14;
  localparam int CW = 16;
  localparam int LN = 64;
  localparam int NT = 9;
  localparam int AWB = 4;
  localparam int SW = 34;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          cfg_we;
  logic          cfg_sel;
  logic [AWB-1:0] cfg_addr;
  logic [CW-1:0] cfg_wdata;
  logic          cfg_commit;
  logic          out_valid;
  logic [SW-1:0] out_data;

  stf_sparse_fir uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_commit (cfg_commit),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  always #10 clk = ~clk;  // 50 MHz

  int     n_checks = 0;
  int     n_fail   = 0;
  bit     done     = 0;
  string  cur_req  = "R1";
  longint cyc      = 0;

  // Reference model state.
  int     hist[$];
  int     act_d[NT], act_c[NT], shd_d[NT], shd_c[NT];
  longint due_q[$];
  longint val_q[$];

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  task automatic tick(input bit v, input int x, input bit we, input bit sel,
                      input int addr, input int data, input bit cm);
    longint acc;
    in_valid   = v;
    in_data    = DW'(x);
    cfg_we     = we;
    cfg_sel    = sel;
    cfg_addr   = AWB'(addr);
    cfg_wdata  = CW'(data);
    cfg_commit = cm;
    // Model order: sample with old profile, then commit, then write to shadow.
    if (v) begin
      hist.push_front(x);
      if (hist.size() > LN) void'(hist.pop_back());
      acc = 0;
      for (int t = 0; t < NT; t++) begin
        if (act_d[t] < hist.size()) acc += longint'(act_c[t]) * longint'(hist[act_d[t]]);
      end
      due_q.push_back(cyc + 3);
      val_q.push_back(acc);
    end
    if (cm) begin
      for (int t = 0; t < NT; t++) begin
        act_d[t] = shd_d[t];
        act_c[t] = shd_c[t];
      end
    end
    if (we && addr < NT) begin
      if (sel) shd_c[addr] = int'($signed(CW'(data)));
      else     shd_d[addr] = (data > LN - 1) ? LN - 1 : data;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    n_checks++;
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      if (out_valid !== 1'b1) begin
        n_fail++;
        $display("FAIL R3 out_valid cycle %0d: actual=%b expected=1", cyc, out_valid);
      end else if (longint'($signed(out_data)) != val_q[0]) begin
        n_fail++;
        $display("FAIL %s out_data cycle %0d: actual=%0d expected=%0d",
                 cur_req, cyc, longint'($signed(out_data)), val_q[0]);
      end
      void'(due_q.pop_front());
      void'(val_q.pop_front());
    end else if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R3 out_valid cycle %0d: actual=%b expected=0", cyc, out_valid);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int p_dly[NT] = '{0, 1, 2, 5, 9, 17, 30, 47, 63};
    int p_cof[NT] = '{1200, -700, 3000, -32768, 32767, 15, -4096, 250, 9999};
    for (int t = 0; t < NT; t++) begin
      act_d[t] = 0; act_c[t] = 0; shd_d[t] = 0; shd_c[t] = 0;
    end
    rst_n = 1'b0;
    in_valid = 0; in_data = '0; cfg_we = 0; cfg_sel = 0;
    cfg_addr = '0; cfg_wdata = '0; cfg_commit = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state at the ports.
    n_checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: actual=%b/%0d expected=0/0", out_valid, out_data);
    end
    // R1: zero profile gives zero results.
    cur_req = "R1";
    for (int i = 0; i < 8; i++) tick(1, 100 * i + 7, 0, 0, 0, 0, 0);

    // R5: writes alone leave the results unchanged (still zero).
    cur_req = "R5";
    for (int t = 0; t < NT; t++) begin
      tick(1, 3 * t - 11, 1, 0, t, p_dly[t], 0);
      tick(1, 5 - t, 1, 1, t, p_cof[t], 0);
    end
    for (int i = 0; i < 4; i++) tick(1, 77 * i, 0, 0, 0, 0, 0);

    // R6: commit together with a sample; that sample still uses the old profile.
    cur_req = "R6";
    tick(1, 4321, 0, 0, 0, 0, 1);
    // R2 and R10: ramp through delays 0 and LEN-1.
    cur_req = "R2";
    for (int i = 0; i < 80; i++) tick(1, (i * 37) % 8000 - 4000, 0, 0, 0, 0, 0);
    idle(4);

    // R4: gaps between samples.
    cur_req = "R4";
    for (int i = 0; i < 90; i++) tick((i % 3) == 0, i * 91 - 4000, 0, 0, 0, 0, 0);

    // R2: full-scale extremes with all coefficients at the negative limit.
    cur_req = "R2";
    for (int t = 0; t < NT; t++) tick(0, 0, 1, 1, t, -32768, 0);
    tick(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 80; i++) tick(1, (i % 2) ? 8191 : -8192, 0, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) tick(1, -8192, 0, 0, 0, 0, 0);

    // R7: a write in the commit cycle is not taken by that commit.
    cur_req = "R7";
    for (int t = 0; t < NT; t++) tick(0, 0, 1, 1, t, p_cof[t], 0);
    tick(1, 555, 1, 1, 0, 20000, 1);
    for (int i = 0; i < 20; i++) tick(1, i * 13 - 100, 0, 0, 0, 0, 0);
    tick(1, 99, 0, 0, 0, 0, 1);
    for (int i = 0; i < 20; i++) tick(1, i * 17 - 150, 0, 0, 0, 0, 0);

    // R8: out-of-range delays clamp to LEN-1.
    cur_req = "R8";
    tick(0, 0, 1, 0, 1, 1000, 0);
    tick(0, 0, 1, 0, 2, 64, 0);
    tick(0, 0, 1, 0, 3, 65535, 0);
    tick(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 70; i++) tick(1, i * 111 - 3800, 0, 0, 0, 0, 0);

    // R9: writes to slots at or above TAPS change nothing.
    cur_req = "R9";
    tick(0, 0, 1, 1, 9, 12345, 0);
    tick(0, 0, 1, 0, 15, 3, 0);
    tick(0, 0, 1, 1, 12, -5, 0);
    tick(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 30; i++) tick(1, 2000 - i * 97, 0, 0, 0, 0, 0);

    // R2/R6/R7: random mix of samples, writes and commits.
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 16);
      tick($urandom % 4 != 0, int'($urandom % 16384) - 8192,
           r < 2, r[0], int'($urandom % 16),
           (r[0]) ? int'($urandom % 65536) : int'($urandom % 80),
           $urandom % 16 == 0);
    end
    idle(6);
    summary();
  end

endmodule